// File: doc/BRIEF.md
# Clock phase-shift step sequencer

This block drives the fine phase-adjust port of an on-chip clock manager. Software or a control loop hands it a signed step count. The block then moves the clock phase one tap at a time. For each tap it raises a one-cycle step strobe together with a direction select. It then waits for the clock manager to acknowledge that tap before it issues the next one. It repeats this until the count is used up.

The block does not rely on the clock manager's overflow status to know where the phase sits. It keeps its own signed position counter, which changes only when a tap is acknowledged. It refuses any tap that would carry that counter past a configurable limit. The overflow input may rise and then toggle without settling. Any high level seen while a tap is outstanding marks the current direction as saturated. Further taps in that direction are then suppressed, and no extra steps are counted. A tap that is acknowledged in the opposite direction lifts that mark. A missing acknowledge is caught by a timeout.

Top module: `phase_step_seq`

## Requirements
- R1: After reset `busy`, `done`, `ps_en`, `clamped`, `saturated` and `timeout_err` are 0 and `position` is 0.
- R2: `ps_en` is high for exactly one cycle per tap. No further `ps_en` pulse occurs until `ps_done` has been received for the outstanding tap.
- R3: A request with a positive count drives `ps_inc` = 1 with every pulse, and a negative count drives `ps_inc` = 0. Without limit, saturation or timeout, the number of pulses equals the magnitude of the count.
- R4: `position` (two's complement, POS_W bits) changes only in the cycle after `ps_done` is accepted for an issued tap, by +1 when `ps_inc` = 1 and by -1 otherwise. A `ps_done` while idle has no effect.
- R5: `position` never leaves the range -LIMIT..+LIMIT. A tap that would cross it is not issued. The request then ends early with `clamped` = 1. `clamped` is cleared when the next request is accepted.
- R6: If `ps_ovf` is high in any cycle while a tap is outstanding, that tap still counts and `saturated` becomes 1. Requests in that same direction then issue no further pulses. Such a request ends with `clamped` = 0.
- R7: `saturated` stays set across requests. It clears only when a tap in the opposite direction is acknowledged with `ps_ovf` low throughout that tap.
- R8: If `ps_done` does not arrive within TIMEOUT cycles of waiting, the request aborts with `timeout_err` = 1 and `done` pulses. `position` is unchanged and `timeout_err` clears when the next request is accepted.
- R9: `req_valid` while `busy` = 1 is ignored: the running request completes unchanged.
- R10: A zero count accepted while idle issues no pulse and raises `done` in the cycle after acceptance.
- R11: `done` is a one-cycle pulse at the end of every accepted request. `busy` is 0 in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-adjust clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_steps | input | REQ_W | Signed tap count of the request |
| ps_en | output | 1 | One-cycle tap strobe to the clock manager |
| ps_inc | output | 1 | Tap direction, 1 = increase phase |
| ps_done | input | 1 | Tap acknowledge from the clock manager |
| ps_ovf | input | 1 | Overflow status from the clock manager, may toggle |
| busy | output | 1 | A request is in progress |
| done | output | 1 | Request finished (pulse) |
| position | output | POS_W | Signed mirror of the tap position |
| clamped | output | 1 | Last request was cut short by the limit |
| saturated | output | 1 | Overflow seen; taps in that direction blocked |
| timeout_err | output | 1 | Last request aborted waiting for acknowledge |

## Verification
The hardest situation to reach is an overflow input that toggles while a tap is outstanding. It has to be followed by a reversal, so that both the setting and the clearing of saturation are seen. The bench models the clock manager with a programmable acknowledge delay of several cycles. While overflow mode is on, it inverts `ps_ovf` every cycle, so each outstanding tap sees at least one high sample. The timeout is reached by muting the acknowledge model entirely. A second request is injected while the first is still waiting, which exercises the ignored-request case.

// File: rtl/phase_step_seq.sv
module phase_step_seq #(
  parameter int POS_W   = 10,
  parameter int REQ_W   = 10,
  parameter int LIMIT   = 255,
  parameter int TIMEOUT = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [REQ_W-1:0] req_steps,
  output logic             ps_en,
  output logic             ps_inc,
  input  logic             ps_done,
  input  logic             ps_ovf,
  output logic             busy,
  output logic             done,
  output logic [POS_W-1:0] position,
  output logic             clamped,
  output logic             saturated,
  output logic             timeout_err
);
  localparam int TMO_W = $clog2(TIMEOUT + 1);
  localparam logic signed [POS_W-1:0] LIM_P = POS_W'(LIMIT);
  localparam logic signed [POS_W-1:0] LIM_N = -LIM_P;
  localparam logic signed [POS_W-1:0] ONE   = POS_W'(1);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} st_t;

  st_t                     st;
  logic [REQ_W-1:0]        remain;
  logic                    dir, sat_dir, ovf_seen;
  logic [TMO_W-1:0]        tmo;
  logic signed [POS_W-1:0] pos;

  wire             req_neg   = req_steps[REQ_W-1];
  wire [REQ_W-1:0] req_mag   = req_neg ? -req_steps : req_steps;
  wire             at_limit  = dir ? (pos >= LIM_P) : (pos <= LIM_N);
  wire             sat_block = saturated && (sat_dir == dir);

  assign busy     = (st != S_IDLE);
  assign ps_inc   = dir;
  assign position = pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      remain      <= '0;
      dir         <= 1'b1;
      sat_dir     <= 1'b1;
      ovf_seen    <= 1'b0;
      tmo         <= '0;
      pos         <= '0;
      ps_en       <= 1'b0;
      done        <= 1'b0;
      clamped     <= 1'b0;
      saturated   <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      ps_en <= 1'b0;
      done  <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          clamped     <= 1'b0;
          timeout_err <= 1'b0;
          if (req_steps == '0) begin
            done <= 1'b1;
          end else begin
            remain <= req_mag;
            dir    <= !req_neg;
            st     <= S_ISSUE;
          end
        end
        S_ISSUE: begin
          if (remain == '0 || sat_block) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else if (at_limit) begin
            clamped <= 1'b1;
            done    <= 1'b1;
            st      <= S_IDLE;
          end else begin
            ps_en    <= 1'b1;
            tmo      <= '0;
            ovf_seen <= 1'b0;
            st       <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (ps_done) begin
            pos    <= dir ? pos + ONE : pos - ONE;
            remain <= remain - 1'b1;
            st     <= S_ISSUE;
            if (ovf_seen || ps_ovf) begin
              saturated <= 1'b1;
              sat_dir   <= dir;
            end else if (sat_dir != dir) begin
              saturated <= 1'b0;
            end
          end else begin
            if (ps_ovf) ovf_seen <= 1'b1;
            if (tmo == TMO_W'(TIMEOUT - 1)) begin
              timeout_err <= 1'b1;
              done        <= 1'b1;
              st          <= S_IDLE;
            end else begin
              tmo <= tmo + 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/phase_step_seq_chk.sv
module phase_step_seq_chk #(
  parameter int POS_W = 10,
  parameter int LIMIT = 255
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ps_en,
  input logic             ps_done,
  input logic             busy,
  input logic             done,
  input logic             timeout_err,
  input logic [POS_W-1:0] position
);
  logic outst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                outst <= 1'b0;
    else if (ps_en)            outst <= 1'b1;
    else if (ps_done || !busy) outst <= 1'b0;
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ps_en);

  p_en_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ps_en |=> !ps_en);

  p_one_outstanding_r2: assert property (@(posedge clk) disable iff (!rst_n)
    outst |-> !ps_en);

  p_pos_on_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (position != $past(position)) |-> ($past(ps_done) && $past(busy)));

  p_pos_unit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (position != $past(position)) |->
      (($signed(position) - $signed($past(position)) == 1) ||
       ($signed(position) - $signed($past(position)) == -1)));

  p_pos_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed(position) <= LIMIT) && ($signed(position) >= -LIMIT));

  p_tmo_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> done);

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind phase_step_seq phase_step_seq_chk #(.POS_W(POS_W), .LIMIT(LIMIT)) chk_i (
  .clk(clk), .rst_n(rst_n), .ps_en(ps_en), .ps_done(ps_done), .busy(busy),
  .done(done), .timeout_err(timeout_err), .position(position)
);

// File: tb/phase_step_seq_tb_top.sv
`timescale 1ns/1ps
module phase_step_seq_tb_top;
  localparam int POS_W = 10, REQ_W = 10, LIM = 20, TMO = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             req_valid = 1'b0;
  logic [REQ_W-1:0] req_steps = '0;
  logic             ps_en, ps_inc, ps_done, busy, done, clamped, saturated, timeout_err;
  logic             ps_ovf = 1'b0;
  logic [POS_W-1:0] position;

  phase_step_seq #(.POS_W(POS_W), .REQ_W(REQ_W), .LIMIT(LIM), .TIMEOUT(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_steps(req_steps),
    .ps_en(ps_en), .ps_inc(ps_inc), .ps_done(ps_done), .ps_ovf(ps_ovf),
    .busy(busy), .done(done), .position(position), .clamped(clamped),
    .saturated(saturated), .timeout_err(timeout_err));

  int vec = 0, bad = 0;
  int rcnt = -1, rdelay = 2, en_cnt = 0, total = 0;
  bit ron = 1, exp_inc = 1, inc_err = 0, proto_err = 0, ovf_mode = 0;
  logic rdone = 1'b0, spur = 1'b0, prev_en = 1'b0;
  assign ps_done = rdone | spur;

  int mpos = 0, msat = 0, msatdir = 1;

  always @(negedge clk) begin
    rdone = 1'b0;
    if (rcnt == 0) begin rdone = 1'b1; rcnt = -1; end
    else if (rcnt > 0) rcnt--;
    if (ps_en === 1'b1) begin
      en_cnt++;
      if (ps_inc !== exp_inc) inc_err = 1;
      if (prev_en || rcnt >= 0 || rdone) proto_err = 1;
      if (ron) rcnt = rdelay - 1;
    end
    prev_en = ps_en;
    ps_ovf = ovf_mode ? ~ps_ovf : 1'b0;
  end

  always @(posedge clk) begin
    total++;
    if (total > 150000) begin
      bad++;
      $display("FAIL watchdog: got %0d cycles expected fewer", total);
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_req(int n, output int cyc);
    en_cnt = 0; inc_err = 0; exp_inc = (n > 0);
    @(negedge clk); req_valid = 1'b1; req_steps = REQ_W'(n);
    @(negedge clk); req_valid = 1'b0; cyc = 1;
    while (done !== 1'b1 && cyc < 5000) begin @(negedge clk); cyc++; end
    chk(done === 1'b1, "R11", "done pulse seen", int'(done), 1);
    chk(busy === 1'b0, "R11", "busy with done", int'(busy), 0);
  endtask

  task automatic do_req(int n, string tag);
    int mag, dir, room, steps, expcl, cyc;
    mag = (n < 0) ? -n : n;
    dir = (n > 0) ? 1 : 0;
    room = dir ? (LIM - mpos) : (mpos + LIM);
    steps = 0; expcl = 0;
    if (mag != 0 && !(msat && msatdir == dir)) begin
      steps = (mag < room) ? mag : room;
      if (ovf_mode && steps > 0) begin
        steps = 1; msat = 1; msatdir = dir;
      end else begin
        expcl = (mag > room);
        if (steps > 0 && msat && msatdir != dir) msat = 0;
      end
    end
    mpos += dir ? steps : -steps;
    run_req(n, cyc);
    chk(en_cnt == steps, "R3", {tag, " pulse count"}, en_cnt, steps);
    chk(!inc_err, "R3", {tag, " direction select"}, int'(inc_err), 0);
    chk(int'($signed(position)) == mpos, "R4", {tag, " position"}, int'($signed(position)), mpos);
    chk(int'(clamped) == expcl, "R5", {tag, " clamped"}, int'(clamped), expcl);
    chk(int'(saturated) == msat, "R6", {tag, " saturated"}, int'(saturated), msat);
    if (mag == 0) chk(cyc == 1, "R10", "zero request latency", cyc, 1);
  endtask

  initial begin
    int cyc, p0;
    repeat (3) @(negedge clk);
    chk(busy === 0 && done === 0 && ps_en === 0, "R1", "reset controls", int'({busy, done, ps_en}), 0);
    chk(position === '0, "R1", "reset position", int'(position), 0);
    chk(clamped === 0 && saturated === 0 && timeout_err === 0, "R1", "reset flags",
        int'({clamped, saturated, timeout_err}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 48; i++) begin
      rdelay = 1 + (i % 4);
      do_req(((i * 37 + 11) % 61) - 30, "sweep");
    end

    rdelay = 2;
    do_req(LIM - mpos + 3, "R5 limit overshoot");
    chk(clamped === 1'b1, "R5", "clamp at top", int'(clamped), 1);
    do_req(2, "R5 at limit");
    do_req(0, "R10 zero");

    rdelay = 3; ovf_mode = 1;
    do_req(-5, "R6 glitching ovf");
    chk(saturated === 1'b1, "R6", "saturated set", int'(saturated), 1);
    do_req(-3, "R6 blocked dir");
    ovf_mode = 0;
    @(negedge clk);
    do_req(-2, "R7 still blocked");
    do_req(4, "R7 reverse clears");
    chk(saturated === 1'b0, "R7", "saturated cleared", int'(saturated), 0);
    do_req(-4, "R7 free again");

    do_req(-mpos, "R9 recentre");
    p0 = mpos;
    en_cnt = 0; inc_err = 0; exp_inc = 1; rdelay = 3;
    @(negedge clk); req_valid = 1'b1; req_steps = REQ_W'(4);
    @(negedge clk); req_valid = 1'b0;
    repeat (2) @(negedge clk);
    req_valid = 1'b1; req_steps = REQ_W'(-7);
    @(negedge clk); req_valid = 1'b0;
    cyc = 0;
    while (done !== 1'b1 && cyc < 5000) begin @(negedge clk); cyc++; end
    mpos = p0 + 4;
    chk(en_cnt == 4, "R9", "pulses with ignored request", en_cnt, 4);
    chk(int'($signed(position)) == mpos, "R9", "position", int'($signed(position)), mpos);
    @(negedge clk);
    chk(busy === 1'b0, "R9", "idle after request", int'(busy), 0);

    spur = 1'b1; @(negedge clk); spur = 1'b0; @(negedge clk);
    chk(int'($signed(position)) == mpos, "R4", "idle ps_done ignored", int'($signed(position)), mpos);

    ron = 0;
    run_req(3, cyc);
    chk(cyc == TMO + 2, "R8", "timeout latency", cyc, TMO + 2);
    chk(timeout_err === 1'b1, "R8", "timeout flag", int'(timeout_err), 1);
    chk(en_cnt == 1, "R8", "single pulse before abort", en_cnt, 1);
    chk(int'($signed(position)) == mpos, "R8", "position kept", int'($signed(position)), mpos);
    ron = 1;
    do_req(1, "R8 recovery");
    chk(timeout_err === 1'b0, "R8", "flag cleared", int'(timeout_err), 0);

    chk(!proto_err, "R2", "strobe protocol", int'(proto_err), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule